// File: doc/BRIEF.md
# Tag-Matching Reservation Station Bank

This block holds a small group of pending operations in front of one class of functional unit. On issue, each operation brings an opcode and two source operands. Every operand comes either as a ready value (producer tag zero) or as the nonzero tag of the station that will later produce it. The bank watches a shared result bus. Whenever the bus tag equals the tag an operand is waiting on, that operand takes the bus data and its tag becomes zero.

Once a station has both tags at zero it is offered to the functional unit through a valid/ready handshake. When more than one station is ready, the lowest index goes first. A station that has been accepted stays occupied until its own result appears on the bus, and only then can a new issue use it. Each station carries a fixed nonzero tag, `TAG_BASE` plus its index, so the value zero always means "present".

Top module: `rsb_bank`

## Requirements
- R1: After reset every station is free, `issue_ready` is 1 and `disp_valid` is 0.
- R2: An issue with `issue_valid` and `issue_ready` both high goes to the lowest-indexed free station. `issue_tag` gives that station's tag, `TAG_BASE + index`, which is 1, 2 and 3 with the default parameters.
- R3: When all stations are busy, `issue_ready` is 0 and an `issue_valid` pulse is ignored: it creates no station and no later dispatch.
- R4: An issued operand whose tag is 0 keeps the issued value. An operand with a nonzero tag keeps the station from dispatching until that operand is filled.
- R5: A waiting operand loads `bus_data` only in a cycle where `bus_valid` is 1 and `bus_tag` equals its stored tag. Its tag then becomes 0.
- R6: When an issued operand's tag matches the bus tag in the issue cycle itself, the operand captures that bus data at issue.
- R7: `disp_valid` is raised only for a station whose two tags are zero and which has not yet been accepted. Among such stations the lowest index is offered, and `disp_tag` gives its tag.
- R8: While `disp_valid` is 1 and `disp_ready` is 0, the next cycle keeps `disp_valid` high with the same tag, opcode and operands, even if a lower-indexed station becomes ready in the meantime.
- R9: An accepted station is never offered again. It stays busy, and so keeps counting against `issue_ready`, until the bus carries its own tag with `bus_valid` high. It is free from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | At least one station is free |
| issue_op | input | OP_W | Opcode to store |
| issue_vj | input | DATA_W | First operand value |
| issue_qj | input | TAG_W | First operand producer tag, 0 = value present |
| issue_vk | input | DATA_W | Second operand value |
| issue_qk | input | TAG_W | Second operand producer tag, 0 = value present |
| issue_tag | output | TAG_W | Tag of the station an issue would take this cycle |
| bus_valid | input | 1 | Result bus carries a result |
| bus_tag | input | TAG_W | Tag of the station that produced the result |
| bus_data | input | DATA_W | Result value |
| disp_valid | output | 1 | A ready station is offered to the unit |
| disp_ready | input | 1 | Unit accepts the offered station |
| disp_op | output | OP_W | Offered opcode |
| disp_vj | output | DATA_W | Offered first operand |
| disp_vk | output | DATA_W | Offered second operand |
| disp_tag | output | TAG_W | Tag of the offered station |

## Verification
A wrong tag on a pending operand shows up at the dispatch port. Either the station is never offered, or it is offered with the wrong operand value one cycle after the broadcast that should have filled it. A stale busy or accepted flag shows up as an `issue_ready` that stays low, a reused tag on the next issue, or a second offer of the same tag, all visible within a cycle or two of the result broadcast. Broadcasts are placed in the issue cycle and while an offer is being held, so that lost wakeups and unstable offers surface at once.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

   // where an operand register takes its next value from
   typedef enum logic [1:0] {
      SRC_HOLD      = 2'd0,
      SRC_ISSUE     = 2'd1,
      SRC_BUS_ISSUE = 2'd2,
      SRC_BUS_LATER = 2'd3
   } opnd_src_e;

endpackage

// File: rtl/rsb_pick.sv
module rsb_pick #(
   parameter int N  = 3,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   // lowest index wins: scan from the top so the last hit is the lowest
   always_comb begin
      gnt = '0;
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
            idx    = IW'(i);
            any    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/rsb_operand.sv
module rsb_operand
   import rsb_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] in_v,
   input  logic [TAG_W-1:0]  in_q,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   output logic [DATA_W-1:0] val,
   output logic [TAG_W-1:0]  q
);
   opnd_src_e src;

   always_comb begin
      if (load) begin
         if (in_q != '0 && bus_valid && bus_tag == in_q) src = SRC_BUS_ISSUE;
         else                                            src = SRC_ISSUE;
      end else if (q != '0 && bus_valid && bus_tag == q) begin
         src = SRC_BUS_LATER;
      end else begin
         src = SRC_HOLD;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val <= '0;
         q   <= '0;
      end else begin
         unique case (src)
            SRC_ISSUE: begin
               val <= in_v;
               q   <= in_q;
            end
            SRC_BUS_ISSUE, SRC_BUS_LATER: begin
               val <= bus_data;
               q   <= '0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rsb_slot.sv
module rsb_slot #(
   parameter int              DATA_W = 64,
   parameter int              TAG_W  = 4,
   parameter int              OP_W   = 4,
   parameter logic [TAG_W-1:0] MY_TAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic [OP_W-1:0]   in_op,
   input  logic [DATA_W-1:0] in_vj,
   input  logic [TAG_W-1:0]  in_qj,
   input  logic [DATA_W-1:0] in_vk,
   input  logic [TAG_W-1:0]  in_qk,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              grant,
   output logic              busy,
   output logic              rdy,
   output logic [OP_W-1:0]   op,
   output logic [DATA_W-1:0] vj,
   output logic [DATA_W-1:0] vk
);
   logic              sent;
   logic [TAG_W-1:0]  qj, qk;
   logic              own_result;

   assign own_result = busy && sent && bus_valid && bus_tag == MY_TAG;
   assign rdy        = busy && !sent && qj == '0 && qk == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sent <= 1'b0;
         op   <= '0;
      end else if (alloc) begin
         busy <= 1'b1;
         sent <= 1'b0;
         op   <= in_op;
      end else if (own_result) begin
         busy <= 1'b0;
         sent <= 1'b0;
      end else if (grant) begin
         sent <= 1'b1;
      end
   end

   rsb_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opj (
      .clk(clk), .rst_n(rst_n), .load(alloc), .in_v(in_vj), .in_q(in_qj),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .val(vj), .q(qj)
   );

   rsb_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opk (
      .clk(clk), .rst_n(rst_n), .load(alloc), .in_v(in_vk), .in_q(in_qk),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .val(vk), .q(qk)
   );
endmodule

// File: rtl/rsb_bank.sv
module rsb_bank #(
   parameter int NUM_RS   = 3,
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter int OP_W     = 4,
   parameter int TAG_BASE = 1,
   parameter bit HOLD_SEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   output logic              issue_ready,
   input  logic [OP_W-1:0]   issue_op,
   input  logic [DATA_W-1:0] issue_vj,
   input  logic [TAG_W-1:0]  issue_qj,
   input  logic [DATA_W-1:0] issue_vk,
   input  logic [TAG_W-1:0]  issue_qk,
   output logic [TAG_W-1:0]  issue_tag,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_vj,
   output logic [DATA_W-1:0] disp_vk,
   output logic [TAG_W-1:0]  disp_tag
);
   localparam int IW      = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;
   localparam int TAG_TOP = TAG_BASE + NUM_RS - 1;

   if (NUM_RS < 1) begin : g_bad_num
      $error("rsb_bank: NUM_RS must be at least 1");
   end
   if (TAG_BASE < 1) begin : g_bad_base
      $error("rsb_bank: TAG_BASE must be nonzero, zero marks a present operand");
   end
   if (TAG_TOP >= (1 << TAG_W)) begin : g_bad_tagw
      $error("rsb_bank: TAG_W too narrow for the station tags");
   end

   logic [NUM_RS-1:0] s_busy, s_rdy, alloc_gnt, alloc_vec, grant_vec;
   logic [OP_W-1:0]   s_op [NUM_RS];
   logic [DATA_W-1:0] s_vj [NUM_RS];
   logic [DATA_W-1:0] s_vk [NUM_RS];
   logic [IW-1:0]     alloc_idx, pick_idx, sel_idx;
   logic              alloc_any, pick_any;
   logic [NUM_RS-1:0] pick_gnt;

   rsb_pick #(.N(NUM_RS), .IW(IW)) u_alloc (
      .req(~s_busy), .gnt(alloc_gnt), .idx(alloc_idx), .any(alloc_any)
   );

   assign issue_ready = alloc_any;
   assign issue_tag   = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
   assign alloc_vec   = (issue_valid && alloc_any) ? alloc_gnt : '0;

   for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
      rsb_slot #(
         .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
         .MY_TAG(TAG_W'(TAG_BASE + i))
      ) u_slot (
         .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[i]),
         .in_op(issue_op), .in_vj(issue_vj), .in_qj(issue_qj),
         .in_vk(issue_vk), .in_qk(issue_qk),
         .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
         .grant(grant_vec[i]), .busy(s_busy[i]), .rdy(s_rdy[i]),
         .op(s_op[i]), .vj(s_vj[i]), .vk(s_vk[i])
      );
   end

   rsb_pick #(.N(NUM_RS), .IW(IW)) u_disp (
      .req(s_rdy), .gnt(pick_gnt), .idx(pick_idx), .any(pick_any)
   );

   if (HOLD_SEL) begin : g_hold
      logic          hold_q;
      logic [IW-1:0] hold_idx_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
         end else begin
            hold_q     <= disp_valid && !disp_ready;
            hold_idx_q <= sel_idx;
         end
      end
      assign sel_idx = hold_q ? hold_idx_q : pick_idx;
   end else begin : g_nohold
      assign sel_idx = pick_idx;
   end

   always_comb begin
      disp_valid = 1'b0;
      disp_op    = '0;
      disp_vj    = '0;
      disp_vk    = '0;
      grant_vec  = '0;
      for (int i = 0; i < NUM_RS; i++) begin
         if (sel_idx == IW'(i)) begin
            disp_valid   = s_rdy[i];
            disp_op      = s_op[i];
            disp_vj      = s_vj[i];
            disp_vk      = s_vk[i];
            grant_vec[i] = s_rdy[i] && disp_ready;
         end
      end
   end

   assign disp_tag = TAG_W'(TAG_BASE) + TAG_W'(sel_idx);
endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
   parameter int NUM_RS   = 3,
   parameter int DATA_W   = 64,
   parameter int TAG_W    = 4,
   parameter int OP_W     = 4,
   parameter int TAG_BASE = 1,
   parameter bit HOLD_SEL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              issue_ready,
   input logic [OP_W-1:0]   issue_op,
   input logic [DATA_W-1:0] issue_vj,
   input logic [TAG_W-1:0]  issue_qj,
   input logic [DATA_W-1:0] issue_vk,
   input logic [TAG_W-1:0]  issue_qk,
   input logic [TAG_W-1:0]  issue_tag,
   input logic              bus_valid,
   input logic [TAG_W-1:0]  bus_tag,
   input logic [DATA_W-1:0] bus_data,
   input logic              disp_valid,
   input logic              disp_ready,
   input logic [OP_W-1:0]   disp_op,
   input logic [DATA_W-1:0] disp_vj,
   input logic [DATA_W-1:0] disp_vk,
   input logic [TAG_W-1:0]  disp_tag
);
   // port-level shadow of occupancy and acceptance per tag
   logic [NUM_RS-1:0] busy_m, sent_m;
   logic              iss_on_busy, disp_on_bad, tag_ok_i, tag_ok_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_m <= '0;
         sent_m <= '0;
      end else begin
         for (int i = 0; i < NUM_RS; i++) begin
            if (issue_valid && issue_ready && issue_tag == TAG_W'(TAG_BASE + i)) begin
               busy_m[i] <= 1'b1;
               sent_m[i] <= 1'b0;
            end else if (bus_valid && sent_m[i] && bus_tag == TAG_W'(TAG_BASE + i)) begin
               busy_m[i] <= 1'b0;
               sent_m[i] <= 1'b0;
            end else if (disp_valid && disp_ready && disp_tag == TAG_W'(TAG_BASE + i)) begin
               sent_m[i] <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      iss_on_busy = 1'b0;
      disp_on_bad = 1'b0;
      for (int i = 0; i < NUM_RS; i++) begin
         if (issue_tag == TAG_W'(TAG_BASE + i) && busy_m[i]) iss_on_busy = 1'b1;
         if (disp_tag == TAG_W'(TAG_BASE + i) && (sent_m[i] || !busy_m[i])) disp_on_bad = 1'b1;
      end
      tag_ok_i = int'(issue_tag) >= TAG_BASE && int'(issue_tag) < TAG_BASE + NUM_RS;
      tag_ok_d = int'(disp_tag) >= TAG_BASE && int'(disp_tag) < TAG_BASE + NUM_RS;
   end

   // R2
   issue_to_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_ready) |-> (tag_ok_i && !iss_on_busy));

   // R3
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy_m) |-> !issue_ready);

   // R7
   disp_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> tag_ok_d);

   // R8
   offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_tag) &&
         $stable(disp_op) && $stable(disp_vj) && $stable(disp_vk)));

   // R9
   no_redispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> !disp_on_bad);
endmodule

bind rsb_bank rsb_bank_chk #(
   .NUM_RS(NUM_RS), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W),
   .TAG_BASE(TAG_BASE), .HOLD_SEL(HOLD_SEL)
) u_chk (.*);

// File: tb/rsb_bank_tb.sv
`timescale 1ns/1ps
module rsb_bank_tb;
   localparam int DW = 64;
   localparam int TW = 4;
   localparam int OW = 4;

   typedef struct packed {
      logic [OW-1:0] op;
      logic [DW-1:0] vj;
      logic [TW-1:0] qj;
      logic [DW-1:0] vk;
      logic [TW-1:0] qk;
      logic [DW-1:0] bd;
   } vec_t;

   // bus tags 5..9 belong to producers outside this bank
   localparam vec_t VECS [5] = '{
      '{op: 4'h1, vj: 64'h11, qj: 4'd0, vk: 64'h22, qk: 4'd0, bd: 64'h0},
      '{op: 4'h2, vj: 64'hDEAD, qj: 4'd5, vk: 64'h33, qk: 4'd0, bd: 64'hA5A5_0001},
      '{op: 4'h3, vj: 64'h44, qj: 4'd0, vk: 64'hBEEF, qk: 4'd6, bd: 64'h1234_5678_9ABC_DEF0},
      '{op: 4'h4, vj: 64'h1, qj: 4'd7, vk: 64'h2, qk: 4'd8, bd: 64'hFFFF_0000_FFFF_0000},
      '{op: 4'h5, vj: 64'h9, qj: 4'd9, vk: 64'h8, qk: 4'd9, bd: 64'h0F0F}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0, issue_ready;
   logic [OW-1:0] issue_op = '0;
   logic [DW-1:0] issue_vj = '0, issue_vk = '0;
   logic [TW-1:0] issue_qj = '0, issue_qk = '0, issue_tag;
   logic          bus_valid = 1'b0;
   logic [TW-1:0] bus_tag = '0;
   logic [DW-1:0] bus_data = '0;
   logic          disp_valid, disp_ready = 1'b0;
   logic [OW-1:0] disp_op;
   logic [DW-1:0] disp_vj, disp_vk;
   logic [TW-1:0] disp_tag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rsb_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_op(issue_op),
      .issue_vj(issue_vj), .issue_qj(issue_qj), .issue_vk(issue_vk), .issue_qk(issue_qk),
      .issue_tag(issue_tag), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
      .disp_vj(disp_vj), .disp_vk(disp_vk), .disp_tag(disp_tag)
   );

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      chk(act == exp, req, act, exp);
   endtask

   // all tasks start and end at a falling edge
   task automatic issue(input logic [OW-1:0] op, input logic [DW-1:0] vj, input logic [TW-1:0] qj,
                        input logic [DW-1:0] vk, input logic [TW-1:0] qk);
      issue_valid = 1'b1; issue_op = op;
      issue_vj = vj; issue_qj = qj; issue_vk = vk; issue_qk = qk;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] d);
      bus_valid = 1'b1; bus_tag = t; bus_data = d;
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic accept();
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_eq("R1 issue_ready", issue_ready, 1);
      chk_eq("R1 disp_valid", disp_valid, 0);
      chk_eq("R1 issue_tag", issue_tag, 1);

      // table walk: one operation at a time through an empty bank
      for (int n = 0; n < 5; n++) begin
         vec_t v = VECS[n];
         logic [DW-1:0] ej = (v.qj != 0) ? v.bd : v.vj;
         logic [DW-1:0] ek = (v.qk != 0) ? ((v.qk == v.qj) ? v.bd : ~v.bd) : v.vk;
         chk_eq("R2 tag before issue", issue_tag, 1);
         issue(v.op, v.vj, v.qj, v.vk, v.qk);
         if (v.qj != 0 || v.qk != 0) begin
            // R4 waiting operand blocks dispatch
            chk_eq("R4 wait", disp_valid, 0);
            if (v.qj != 0) bcast(v.qj, v.bd);
            if (v.qk != 0 && v.qk != v.qj) begin
               chk_eq("R5 half filled", disp_valid, 0);
               bcast(v.qk, ~v.bd);
            end
         end
         chk_eq("R7 offered", disp_valid, 1);
         chk_eq("R7 disp_tag", disp_tag, 1);
         chk_eq("R7 disp_op", disp_op, v.op);
         chk_eq("R5 disp_vj", disp_vj, ej);
         chk_eq("R5 disp_vk", disp_vk, ek);
         accept();
         chk_eq("R9 not reoffered", disp_valid, 0);
         bcast(4'd1, 64'h0);
         chk_eq("R9 freed", issue_ready, 1);
      end

      // R5 a non-matching broadcast is ignored
      issue(4'h6, 64'h0, 4'd5, 64'h77, 4'd0);
      bcast(4'd6, 64'hBAD);
      chk_eq("R5 wrong tag no wake", disp_valid, 0);
      bcast(4'd5, 64'h600D);
      chk_eq("R5 right tag vj", disp_vj, 64'h600D);
      accept();
      bcast(4'd1, 64'h0);

      // R6 wakeup in the issue cycle
      bus_valid = 1'b1; bus_tag = 4'd7; bus_data = 64'hCAFE;
      issue(4'h7, 64'h0BAD, 4'd7, 64'h55, 4'd0);
      bus_valid = 1'b0;
      chk_eq("R6 offered", disp_valid, 1);
      chk_eq("R6 vj", disp_vj, 64'hCAFE);
      accept();
      bcast(4'd1, 64'h0);

      // R2 R3 fill the bank, each waiting on tag 9
      for (int s = 0; s < 3; s++) begin
         chk_eq("R2 alloc tag", issue_tag, s + 1);
         issue(4'(8 + s), 64'h0, 4'd9, 64'(s), 4'd0);
      end
      chk_eq("R3 full", issue_ready, 0);
      issue(4'hF, 64'h1, 4'd0, 64'h1, 4'd0); // must be ignored
      chk_eq("R3 ignored no offer", disp_valid, 0);
      bcast(4'd9, 64'h99);
      for (int s = 0; s < 3; s++) begin
         chk_eq("R7 lowest first", disp_tag, s + 1);
         chk_eq("R7 op order", disp_op, 8 + s);
         accept();
      end
      chk_eq("R3 ignored issue never offered", disp_valid, 0);
      chk_eq("R9 busy until broadcast", issue_ready, 0);
      bcast(4'd2, 64'h0);
      chk_eq("R9 freed by own tag", issue_ready, 1);
      chk_eq("R2 reuse lowest free", issue_tag, 2);
      issue(4'hC, 64'h5, 4'd0, 64'h6, 4'd0);
      bcast(4'd1, 64'h0);
      bcast(4'd3, 64'h0);
      chk_eq("R2 refill tag", disp_tag, 2);
      accept();
      bcast(4'd2, 64'h0);

      // R8 offer held while a lower station wakes up
      issue(4'hA, 64'h0, 4'd8, 64'h1, 4'd0); // tag 1 waits
      issue(4'hB, 64'h2, 4'd0, 64'h3, 4'd0); // tag 2 ready
      chk_eq("R8 first offer", disp_tag, 2);
      bcast(4'd8, 64'h88);
      chk_eq("R8 held valid", disp_valid, 1);
      chk_eq("R8 held tag", disp_tag, 2);
      chk_eq("R8 held op", disp_op, 4'hB);
      accept();
      chk_eq("R7 then lower", disp_tag, 1);
      chk_eq("R5 late fill", disp_vj, 64'h88);
      accept();
      bcast(4'd1, 64'h0);
      bcast(4'd2, 64'h0);
      chk_eq("R9 all free", issue_ready, 1);

      // R1 reset in the middle of work
      issue(4'h1, 64'h1, 4'd0, 64'h1, 4'd0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk_eq("R1 reset clears offer", disp_valid, 0);
      chk_eq("R1 reset tag", issue_tag, 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule